// File: doc/BRIEF.md
# Interleaved I/Q Word Assembler

This block sits at the input of a transmit signal-processing path. One 12-bit bus carries I and Q samples in alternation. A framing input travels with the bus. The block pairs successive words into parallel I and Q samples and hands each pair downstream with a single-cycle strobe. One word is sampled on every clock edge.

A mode input chooses how the framing input is read.

- **Burst mode:** the framing input marks a burst of pairs. Once a burst has ended, the block feeds zero-valued pairs downstream at the normal pair rate.
- **Continuous mode:** the level of the framing input tags each word. High means I and low means Q. Every word is used, and no zeros are inserted. If the framing input stays static, the block keeps alternating I and Q on its own.

In both modes, a rising edge on the framing input realigns the word phase. The word sampled with that edge becomes the I half of a new pair.

Top module: `iq_word_assembler`

## Requirements
- R1: A synchronous reset clears `i_out` and `q_out` to zero and holds `pair_vld` low. The first word sampled after reset is taken as an I word, in the mode present on `cont_mode` during reset.
- R2: A pair is complete when its Q word is sampled on an edge. After that edge, `i_out` and `q_out` both take the new pair, and `pair_vld` is high for exactly that one cycle. Two consecutive cycles never both carry the strobe.
- R3: In burst mode (`cont_mode` = 0), while `frame_en` is high, words alternate I, Q, I, Q.
- R4: In burst mode, `frame_en` may be low on a word that would start a pair. In that case, the data bus is ignored and zero pairs are emitted: one pair every two cycles, each with the strobe.
- R5: In burst mode, suppose `frame_en` falls while a pair is half done. The word on the bus at that moment is taken as the Q half of the pair, and the pair is emitted with that data.
- R6: In continuous mode (`cont_mode` = 1), no word is replaced by zero. A word sampled with `frame_en` low is passed through as data.
- R7: In continuous mode, words keep alternating I and Q while `frame_en` is held high or held low. A pair is emitted every two cycles.
- R8: When `frame_en` is high and was low at the previous edge, the current word is taken as I in either mode. Any half-assembled pair is discarded, and no strobe is raised in that cycle.
- R9: A change of `cont_mode` is applied only when a pair completes. The pair in progress finishes under the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock; one word is sampled per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 12 | Interleaved I/Q sample word |
| frame_en | input | 1 | Framing and I/Q tag input |
| cont_mode | input | 1 | 1 selects continuous mode; 0 selects burst mode |
| i_out | output | 12 | I sample of the latest pair |
| q_out | output | 12 | Q sample of the latest pair |
| pair_vld | output | 1 | One-cycle strobe marking a new pair on the outputs |

## Verification
The assertions assume that every low stretch of `frame_en` lasts at least one full word period. Under that assumption, a rising edge is always preceded by a sampled low level. They also assume that `cont_mode` is a quasi-static setting and not a per-word signal.

The stimulus meets these assumptions:
- It changes `frame_en` and `cont_mode` only on the falling clock edge.
- It never pulses `frame_en` low for less than one word.
- It switches `cont_mode` only in scripted places, both in the middle of a pair and at a pair boundary.

// File: rtl/iqa_pkg.sv
package iqa_pkg;

  typedef enum logic {
    SLOT_I = 1'b0,
    SLOT_Q = 1'b1
  } slot_e;

  // Burst mode substitutes zero for a word when the frame input is low and
  // either a new pair would start or the pair was already opened with zero.
  function automatic logic zero_substitute(input logic burst,
                                           input logic en,
                                           input slot_e slot,
                                           input logic zero_open);
    return burst && !en && ((slot == SLOT_I) || zero_open);
  endfunction

  // Word actually presented to the pair registers.
  function automatic logic [11:0] word_value(input logic [11:0] raw,
                                             input logic zero);
    return zero ? 12'd0 : raw;
  endfunction

  // Slot that the current word occupies, after edge realignment.
  function automatic slot_e effective_slot(input logic rise, input slot_e held);
    return rise ? SLOT_I : held;
  endfunction

endpackage

// File: rtl/iqa_edge_detect.sv
module iqa_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= level_i;
  end

  assign rise_o = level_i && !level_d;

  // A rise is never reported in two consecutive cycles
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R8
endmodule

// File: rtl/iqa_slot_ctrl.sv
module iqa_slot_ctrl
  import iqa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic rise_i,
  input  logic cont_mode_i,
  output logic take_i_o,
  output logic pair_done_o,
  output logic zero_word_o,
  output logic act_mode_o
);
  slot_e slot_q;
  slot_e slot_eff;
  logic  zero_open_q;
  logic  act_mode_q;

  assign slot_eff    = effective_slot(rise_i, slot_q);
  assign take_i_o    = (slot_eff == SLOT_I);
  assign pair_done_o = (slot_eff == SLOT_Q);
  assign zero_word_o = zero_substitute(!act_mode_q, en_i, slot_eff, zero_open_q);
  assign act_mode_o  = act_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q      <= SLOT_I;
      zero_open_q <= 1'b0;
      act_mode_q  <= cont_mode_i;
    end else if (take_i_o) begin
      slot_q      <= SLOT_Q;
      zero_open_q <= zero_word_o;
    end else begin
      slot_q      <= SLOT_I;
      zero_open_q <= 1'b0;
      act_mode_q  <= cont_mode_i;
    end
  end

  // Mode only moves on a pair boundary
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !pair_done_o |=> $stable(act_mode_q)); // R9
  // A completed pair is always followed by an I word
  AST_I_AFTER_PAIR: assert property (@(posedge clk) disable iff (rst)
    pair_done_o |=> take_i_o); // R2
endmodule

// File: rtl/iqa_pair_reg.sv
module iqa_pair_reg
  import iqa_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_i,
  input  logic              zero_word_i,
  input  logic              take_i_i,
  input  logic              pair_done_i,
  output logic [DATA_W-1:0] i_o,
  output logic [DATA_W-1:0] q_o,
  output logic              vld_o
);
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] i_hold;

  assign word = zero_word_i ? '0 : data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      i_hold <= '0;
      i_o    <= '0;
      q_o    <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= pair_done_i;
      if (take_i_i) i_hold <= word;
      if (pair_done_i) begin
        i_o <= i_hold;
        q_o <= word;
      end
    end
  end

  // Outputs hold between strobes
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !pair_done_i |=> ($stable(i_o) && $stable(q_o))); // R2
endmodule

// File: rtl/iq_word_assembler.sv
module iq_word_assembler
  import iqa_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] data_in,
  input  logic        frame_en,
  input  logic        cont_mode,
  output logic [11:0] i_out,
  output logic [11:0] q_out,
  output logic        pair_vld
);
  localparam int DATA_W = 12;

  logic rise_w;
  logic take_i_w;
  logic pair_done_w;
  logic zero_word_w;
  logic act_mode_w;

  iqa_edge_detect u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (frame_en),
    .rise_o  (rise_w)
  );

  iqa_slot_ctrl u_slot (
    .clk         (clk),
    .rst         (rst),
    .en_i        (frame_en),
    .rise_i      (rise_w),
    .cont_mode_i (cont_mode),
    .take_i_o    (take_i_w),
    .pair_done_o (pair_done_w),
    .zero_word_o (zero_word_w),
    .act_mode_o  (act_mode_w)
  );

  iqa_pair_reg #(.DATA_W(DATA_W)) u_pair (
    .clk         (clk),
    .rst         (rst),
    .data_i      (data_in),
    .zero_word_i (zero_word_w),
    .take_i_i    (take_i_w),
    .pair_done_i (pair_done_w),
    .i_o         (i_out),
    .q_o         (q_out),
    .vld_o       (pair_vld)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (i_out == '0 && q_out == '0 && !pair_vld)); // R1
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    pair_vld |=> !pair_vld); // R2
  AST_RISE_IS_I: assert property (@(posedge clk) disable iff (rst)
    rise_w |=> !pair_vld); // R8
  AST_CONT_PASS: assert property (@(posedge clk) disable iff (rst)
    (act_mode_w && pair_done_w) |=> (q_out == $past(data_in))); // R6
  AST_BURST_ZFILL: assert property (@(posedge clk) disable iff (rst)
    (!act_mode_w && pair_done_w && !frame_en && !$past(frame_en))
      |=> (i_out == '0 && q_out == '0)); // R4
endmodule

// File: tb/iq_word_assembler_tb.sv
`timescale 1ns/1ps
module iq_word_assembler_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] data_in = '0;
  logic        frame_en = 1'b0;
  logic        cont_mode = 1'b0;
  logic [11:0] i_out, q_out;
  logic        pair_vld;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  iq_word_assembler u_dut (
    .clk(clk), .rst(rst), .data_in(data_in), .frame_en(frame_en),
    .cont_mode(cont_mode), .i_out(i_out), .q_out(q_out), .pair_vld(pair_vld)
  );

  task automatic step(input logic [11:0] d, input logic e, input logic m);
    @(negedge clk);
    data_in = d; frame_en = e; cont_mode = m;
    @(posedge clk);
    #1;
  endtask

  task automatic check_none(input string tag);
    total++;
    if (pair_vld !== 1'b0) begin
      bad++;
      $display("FAIL %s: vld=%b expected 0", tag, pair_vld);
    end
  endtask

  task automatic check_pair(input string tag, input logic [11:0] ei,
                            input logic [11:0] eq);
    total++;
    if (pair_vld !== 1'b1 || i_out !== ei || q_out !== eq) begin
      bad++;
      $display("FAIL %s: vld=%b i=%h q=%h expected vld=1 i=%h q=%h",
               tag, pair_vld, i_out, q_out, ei, eq);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    step(12'hFFF, 1'b0, 1'b0);
    step(12'hFFF, 1'b0, 1'b0);
    total++;
    if (i_out !== 0 || q_out !== 0 || pair_vld !== 0) begin
      bad++;
      $display("FAIL R1: i=%h q=%h vld=%b expected 0 0 0", i_out, q_out, pair_vld);
    end
    rst = 1'b0;

    // R3 burst pairs; the first word arrives with a rise (R8)
    for (int k = 0; k < 8; k++) begin
      step(12'h100 + 12'(2*k), 1'b1, 1'b0);
      check_none(k == 0 ? "R8 burst start" : "R3 I word");
      step(12'h101 + 12'(2*k), 1'b1, 1'b0);
      check_pair("R2 R3 burst pair", 12'h100 + 12'(2*k), 12'h101 + 12'(2*k));
    end

    // R5 frame falls mid-pair
    step(12'h201, 1'b1, 1'b0);
    check_none("R5 I word");
    step(12'h202, 1'b0, 1'b0);
    check_pair("R5 completed pair", 12'h201, 12'h202);

    // R4 zero fill at pair rate
    for (int k = 0; k < 4; k++) begin
      step(12'h2A0 + 12'(k), 1'b0, 1'b0);
      check_none("R4 zero I");
      step(12'h2B0 + 12'(k), 1'b0, 1'b0);
      check_pair("R4 zero pair", 12'h000, 12'h000);
    end

    // R8 rise in the Q slot realigns
    step(12'h300, 1'b0, 1'b0);
    check_none("R4 zero I");
    step(12'h301, 1'b1, 1'b0);
    check_none("R8 burst resync");
    step(12'h302, 1'b1, 1'b0);
    check_pair("R8 burst resync pair", 12'h301, 12'h302);

    // R9 mode request mid-pair is deferred
    step(12'h3F0, 1'b0, 1'b0);
    check_none("R9 zero I");
    step(12'h3F1, 1'b0, 1'b1);
    check_pair("R9 deferred mode", 12'h000, 12'h000);

    // R6 R7 continuous, frame static low
    for (int k = 0; k < 6; k++) begin
      step(12'h500 + 12'(2*k), 1'b0, 1'b1);
      check_none("R7 static low I");
      step(12'h501 + 12'(2*k), 1'b0, 1'b1);
      check_pair("R6 R7 static low pair", 12'h500 + 12'(2*k), 12'h501 + 12'(2*k));
    end

    // R7 continuous, frame static high
    for (int k = 0; k < 6; k++) begin
      step(12'h600 + 12'(2*k), 1'b1, 1'b1);
      check_none("R7 static high I");
      step(12'h601 + 12'(2*k), 1'b1, 1'b1);
      check_pair("R7 static high pair", 12'h600 + 12'(2*k), 12'h601 + 12'(2*k));
    end

    // R8 continuous resync from a misaligned tag
    step(12'h700, 1'b0, 1'b1);
    check_none("R7 I word");
    step(12'h701, 1'b0, 1'b1);
    check_pair("R7 pair", 12'h700, 12'h701);
    step(12'h702, 1'b0, 1'b1);
    check_none("R8 half pair");
    step(12'h703, 1'b1, 1'b1);
    check_none("R8 cont resync");
    step(12'h704, 1'b0, 1'b1);
    check_pair("R8 cont resync pair", 12'h703, 12'h704);

    // R6 properly tagged continuous stream
    for (int k = 0; k < 6; k++) begin
      step(12'h800 + 12'(2*k), 1'b1, 1'b1);
      check_none("R6 tagged I");
      step(12'h801 + 12'(2*k), 1'b0, 1'b1);
      check_pair("R6 tagged pair", 12'h800 + 12'(2*k), 12'h801 + 12'(2*k));
    end

    // R9 back to burst at a boundary
    step(12'h900, 1'b1, 1'b1);
    check_none("R9 I word");
    step(12'h901, 1'b0, 1'b0);
    check_pair("R9 old mode pair", 12'h900, 12'h901);
    step(12'h902, 1'b0, 1'b0);
    check_none("R9 burst zero I");
    step(12'h903, 1'b0, 1'b0);
    check_pair("R9 R4 new mode zero", 12'h000, 12'h000);

    // R1 reset during a run, then next word is I in continuous mode
    rst = 1'b1;
    step(12'h0A5, 1'b0, 1'b1);
    total++;
    if (i_out !== 0 || q_out !== 0 || pair_vld !== 0) begin
      bad++;
      $display("FAIL R1 mid-run: i=%h q=%h vld=%b expected 0 0 0", i_out, q_out, pair_vld);
    end
    rst = 1'b0;
    step(12'hA00, 1'b0, 1'b1);
    check_none("R1 first word I");
    step(12'hA01, 1'b0, 1'b1);
    check_pair("R1 first pair", 12'hA00, 12'hA01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule